// File: doc/BRIEF.md
# Dual-Width Parallel Flash Bus Interface

This block models the pin-level bus side of a parallel NOR flash whose data bus can be strapped to 16 or 8 bits wide. It samples the active-low controls (power-down, two chip enables, output enable, write enable), decodes them into one bus mode, and drives the data bus through three separate drive-enable signals: one for the low byte lane, one for data lines 8 to 14, and one for the top data pin. The storage behind the bus is a small internal word array. Writes go straight into that array. There is no command interpreter.

In x16 mode the top data pin is an ordinary data bit. In x8 mode that pin becomes the least significant address input. It picks the high or the low byte of the addressed word, and only the low lane carries data. An identifier mode is entered when a digital input reports the high-voltage condition on the address bus. In that mode the block returns a fixed maker code, a device code, or the protection bit of the sector being addressed.

A ready flag is derived from a busy input, a suspend input and the power-down pin. Every pin is registered once on entry, and the bus outputs are registered once more, so any response appears two clocks after the pins that cause it. The bus itself has no valid/ready flow control: it is a strobe-timed pin interface, so no back-pressure applies.

Top module: `flash_bus_if`

## Requirements
- R1: The device is selected only while both `ce1_n` and `ce2_n` are low. When either one is high (standby), all three drive enables are 0.
- R2: While `pwd_n` is low, all three drive enables are 0, `rdy` is 1, and any write attempt leaves the array unchanged.
- R3: While the device is selected with `oe_n` high and `we_n` high (output disable), all three drive enables are 0.
- R4: A read in x16 mode (`byte_n`=1, `oe_n`=0, `id_volt`=0) asserts `lo_oe`, `mid_oe` and `top_oe`, and drives the stored 16-bit word at `addr` on `dq_out`.
- R5: A read in x8 mode (`byte_n`=0) asserts only `lo_oe`. `dq_out[7:0]` carries word bits 7:0 when `dq_in[15]`=0 and word bits 15:8 when `dq_in[15]`=1. `dq_out[15:8]` is 0.
- R6: A write is committed when the write strobe ends. The write strobe is `we_n` low while the device is selected, `oe_n` is high and `pwd_n` is high. It ends on the rising edge of `we_n` or of either chip enable. An x16 write stores `dq_in[15:0]` at `addr`. An x8 write stores `dq_in[7:0]` into the byte chosen by `dq_in[15]` (1 selects the high byte) and leaves the other byte unchanged.
- R7: While `oe_n` is low, a low `we_n` causes no write: the access is treated as a read.
- R8: In identifier mode (`id_volt`=1 with a read), the block returns a code selected by `addr[1:0]`. The values of `addr[1:0]` select the codes as follows:
  - 00 returns 8'hC2.
  - 01 returns parameter `DEV_CODE` (default 8'hFA).
  - 10 returns `{7'b0, prot_bits[s]}`, where `s` is the sector held in the top `$clog2(NSEC)` bits of `addr`.
  - 11 returns 8'h00.

  The code appears on `dq_out[7:0]` and `dq_out[15:8]` is 0. In x16 mode all three lanes are driven; in x8 mode only `lo_oe` is asserted.
- R9: `rdy` is 0 exactly when `busy_in`=1, `suspend_in`=0 and `pwd_n`=1. It does not depend on the chip enables or on `oe_n`.
- R10: Outputs reflect the pin values sampled two rising clock edges earlier. After reset, all drive enables are 0 and `rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwd_n | input | 1 | Active-low deep power-down |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2_n | input | 1 | Chip enable 2, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | Width strap: 1 = x16, 0 = x8 |
| id_volt | input | 1 | Identifier high-voltage condition detected |
| busy_in | input | 1 | Internal program or erase in progress |
| suspend_in | input | 1 | Erase suspended |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data bus input; bit 15 is the byte select in x8 mode |
| prot_bits | input | NSEC | Protection bit per sector |
| dq_out | output | 16 | Data bus output value |
| lo_oe | output | 1 | Drive enable for data lines 7:0 |
| mid_oe | output | 1 | Drive enable for data lines 14:8 |
| top_oe | output | 1 | Drive enable for data line 15 |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
The bench selects the device with one chip enable at a time. A design that ORs the two enables instead of ANDing them would drive the bus in that case.

In x8 mode the bench toggles the top data pin between byte reads and byte writes. A byte-select inversion would return the wrong byte. A full-word write in byte mode would overwrite the neighbouring byte.

The bench pulls `we_n` low while `oe_n` is low, and also writes during power-down. A design that did not gate its write strobe with those pins would corrupt a word that the bench reads back afterwards.

Identifier reads cover every `addr[1:0]` code, sectors with and without protection, and both widths. The ready flag is checked against the busy input while the chip-enable and output-enable pins are moving.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

  typedef enum logic [2:0] {
    M_PDN,
    M_STBY,
    M_ODIS,
    M_READ,
    M_IDENT,
    M_WRITE
  } bus_mode_e;

  typedef struct packed {
    logic pwd_n;
    logic ce1_n;
    logic ce2_n;
    logic oe_n;
    logic we_n;
    logic byte_n;
    logic id_volt;
    logic busy;
    logic susp;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{pwd_n: 1'b1, ce1_n: 1'b1, ce2_n: 1'b1,
                                oe_n: 1'b1, we_n: 1'b1, byte_n: 1'b1,
                                id_volt: 1'b0, busy: 1'b0, susp: 1'b0};

  localparam logic [7:0] MFR_CODE = 8'hC2;

endpackage

// File: rtl/fbi_pin_sampler.sv
module fbi_pin_sampler
  import fbi_pkg::*;
#(
  parameter int AW   = 6,
  parameter int NSEC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl_in,
  input  logic [AW-1:0]   addr_in,
  input  logic [15:0]     dq_in,
  input  logic [NSEC-1:0] prot_in,
  output ctl_t            ctl_q,
  output logic [AW-1:0]   addr_q,
  output logic [15:0]     dq_q,
  output logic [NSEC-1:0] prot_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_IDLE;
      addr_q <= '0;
      dq_q   <= '0;
      prot_q <= '0;
    end else begin
      ctl_q  <= ctl_in;
      addr_q <= addr_in;
      dq_q   <= dq_in;
      prot_q <= prot_in;
    end
  end

endmodule

// File: rtl/fbi_mode_decode.sv
module fbi_mode_decode
  import fbi_pkg::*;
(
  input  ctl_t      ctl,
  output bus_mode_e mode,
  output logic      strobe
);

  logic selected;

  always_comb begin
    selected = !ctl.ce1_n && !ctl.ce2_n;
    if (!ctl.pwd_n)         mode = M_PDN;
    else if (!selected)     mode = M_STBY;
    else if (!ctl.oe_n)     mode = ctl.id_volt ? M_IDENT : M_READ;
    else if (!ctl.we_n)     mode = M_WRITE;
    else                    mode = M_ODIS;
    strobe = (mode == M_WRITE);
  end

endmodule

// File: rtl/fbi_word_array.sv
module fbi_word_array #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [1:0]    wr_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data
);

  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b]) mem[wr_addr] <= wr_data[8*b +: 8];
    end

    assign rd_data[8*b +: 8] = mem[rd_addr];
  end

endmodule

// File: rtl/fbi_out_stage.sv
module fbi_out_stage
  import fbi_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'hFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  bus_mode_e   mode,
  input  logic        wide,
  input  logic        hi_sel,
  input  logic [15:0] word,
  input  logic [1:0]  id_sel,
  input  logic        prot_hit,
  input  logic        busy,
  input  logic        susp,
  input  logic        pwd_n,
  output logic [15:0] dq_out,
  output logic        lo_oe,
  output logic        mid_oe,
  output logic        top_oe,
  output logic        rdy
);

  logic [15:0] nxt_dq;
  logic        nxt_lo, nxt_mid, nxt_top;
  logic [7:0]  id_byte;

  always_comb begin
    case (id_sel)
      2'd0:    id_byte = MFR_CODE;
      2'd1:    id_byte = DEV_CODE;
      2'd2:    id_byte = {7'b0, prot_hit};
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    nxt_dq  = '0;
    nxt_lo  = 1'b0;
    nxt_mid = 1'b0;
    nxt_top = 1'b0;
    case (mode)
      M_READ: begin
        nxt_lo = 1'b1;
        if (wide) begin
          nxt_mid = 1'b1;
          nxt_top = 1'b1;
          nxt_dq  = word;
        end else begin
          nxt_dq = {8'h00, hi_sel ? word[15:8] : word[7:0]};
        end
      end
      M_IDENT: begin
        nxt_lo  = 1'b1;
        nxt_mid = wide;
        nxt_top = wide;
        nxt_dq  = {8'h00, id_byte};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      lo_oe  <= 1'b0;
      mid_oe <= 1'b0;
      top_oe <= 1'b0;
      rdy    <= 1'b1;
    end else begin
      dq_out <= nxt_dq;
      lo_oe  <= nxt_lo;
      mid_oe <= nxt_mid;
      top_oe <= nxt_top;
      rdy    <= !(busy && !susp && pwd_n);
    end
  end

endmodule

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import fbi_pkg::*;
#(
  parameter int         AW       = 6,
  parameter int         NSEC     = 4,
  parameter logic [7:0] DEV_CODE = 8'hFA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwd_n,
  input  logic            ce1_n,
  input  logic            ce2_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic            byte_n,
  input  logic            id_volt,
  input  logic            busy_in,
  input  logic            suspend_in,
  input  logic [AW-1:0]   addr,
  input  logic [15:0]     dq_in,
  input  logic [NSEC-1:0] prot_bits,
  output logic [15:0]     dq_out,
  output logic            lo_oe,
  output logic            mid_oe,
  output logic            top_oe,
  output logic            rdy
);

  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;

  ctl_t            pin_ctl, s_ctl;
  logic [AW-1:0]   s_addr;
  logic [15:0]     s_dq;
  logic [NSEC-1:0] s_prot;
  bus_mode_e       mode;
  logic            strobe, p_strobe, commit;
  logic [AW-1:0]   w_addr;
  logic [15:0]     w_data;
  logic [1:0]      w_mask;
  logic [15:0]     rd_word;
  logic [SW-1:0]   sect;
  logic            hi_sel;

  assign pin_ctl = '{pwd_n: pwd_n, ce1_n: ce1_n, ce2_n: ce2_n, oe_n: oe_n,
                     we_n: we_n, byte_n: byte_n, id_volt: id_volt,
                     busy: busy_in, susp: suspend_in};

  fbi_pin_sampler #(.AW(AW), .NSEC(NSEC)) u_samp (
    .clk(clk), .rst_n(rst_n), .ctl_in(pin_ctl), .addr_in(addr),
    .dq_in(dq_in), .prot_in(prot_bits), .ctl_q(s_ctl), .addr_q(s_addr),
    .dq_q(s_dq), .prot_q(s_prot)
  );

  fbi_mode_decode u_dec (.ctl(s_ctl), .mode(mode), .strobe(strobe));

  assign hi_sel = s_dq[15];

  // Hold address, data and byte mask while the strobe is active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_strobe <= 1'b0;
      w_addr   <= '0;
      w_data   <= '0;
      w_mask   <= '0;
    end else begin
      p_strobe <= strobe;
      if (strobe) begin
        w_addr <= s_addr;
        if (s_ctl.byte_n) begin
          w_data <= s_dq;
          w_mask <= 2'b11;
        end else begin
          w_data <= {s_dq[7:0], s_dq[7:0]};
          w_mask <= hi_sel ? 2'b10 : 2'b01;
        end
      end
    end
  end

  // Strobe end commits only if neither output enable nor power-down cut it.
  assign commit = p_strobe && !strobe && s_ctl.oe_n && s_ctl.pwd_n;

  fbi_word_array #(.AW(AW)) u_arr (
    .clk(clk), .wr_en(commit), .wr_addr(w_addr), .wr_data(w_data),
    .wr_mask(w_mask), .rd_addr(s_addr), .rd_data(rd_word)
  );

  if (NSEC > 1) begin : g_sect
    assign sect = s_addr[AW-1 -: SW];
  end else begin : g_one
    assign sect = '0;
  end

  fbi_out_stage #(.DEV_CODE(DEV_CODE)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wide(s_ctl.byte_n),
    .hi_sel(hi_sel), .word(rd_word), .id_sel(s_addr[1:0]),
    .prot_hit(s_prot[sect]), .busy(s_ctl.busy), .susp(s_ctl.susp),
    .pwd_n(s_ctl.pwd_n), .dq_out(dq_out), .lo_oe(lo_oe), .mid_oe(mid_oe),
    .top_oe(top_oe), .rdy(rdy)
  );

endmodule

// File: rtl/fbi_checker.sv
module fbi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pwd_n,
  input logic        ce1_n,
  input logic        ce2_n,
  input logic        oe_n,
  input logic        byte_n,
  input logic        id_volt,
  input logic        busy_in,
  input logic        suspend_in,
  input logic [1:0]  addr_lo,
  input logic [15:0] dq_out,
  input logic        lo_oe,
  input logic        mid_oe,
  input logic        top_oe,
  input logic        rdy
);

  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end
  assign warm = (age == 2'd2);

  // R1
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pwd_n, 2) && ($past(ce1_n, 2) || $past(ce2_n, 2)))
      |-> !(lo_oe || mid_oe || top_oe));

  // R2
  pdn_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(pwd_n, 2)) |-> (!(lo_oe || mid_oe || top_oe) && rdy));

  // R5
  x8_upper_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(byte_n, 2)) |-> (!mid_oe && !top_oe));

  // R4
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_oe || top_oe) |-> lo_oe);

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (rdy == !($past(busy_in, 2) && !$past(suspend_in, 2) && $past(pwd_n, 2))));

  // R8
  mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pwd_n, 2) && !$past(ce1_n, 2) && !$past(ce2_n, 2) &&
     !$past(oe_n, 2) && $past(id_volt, 2) && ($past(addr_lo, 2) == 2'b00))
      |-> (dq_out == 16'h00C2 && lo_oe));

endmodule

bind flash_bus_if fbi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
  .oe_n(oe_n), .byte_n(byte_n), .id_volt(id_volt), .busy_in(busy_in),
  .suspend_in(suspend_in), .addr_lo(addr[1:0]), .dq_out(dq_out),
  .lo_oe(lo_oe), .mid_oe(mid_oe), .top_oe(top_oe), .rdy(rdy)
);

// File: tb/flash_bus_if_bench.sv
module flash_bus_if_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NSEC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwd_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic byte_n = 1'b1, id_volt = 1'b0, busy_in = 1'b0, suspend_in = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [15:0]     dq_in = '0;
  logic [NSEC-1:0] prot_bits = 4'b0100;
  logic [15:0]     dq_out;
  logic            lo_oe, mid_oe, top_oe, rdy;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_if #(.AW(AW), .NSEC(NSEC)) u_flash_bus_if (
    .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n), .id_volt(id_volt),
    .busy_in(busy_in), .suspend_in(suspend_in), .addr(addr), .dq_in(dq_in),
    .prot_bits(prot_bits), .dq_out(dq_out), .lo_oe(lo_oe), .mid_oe(mid_oe),
    .top_oe(top_oe), .rdy(rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_bus();
    ce1_n = 1'b1; ce2_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; id_volt = 1'b0;
    settle();
  endtask

  task automatic do_write(input logic wide, input logic [AW-1:0] a, input logic [15:0] d);
    byte_n = wide; addr = a; dq_in = d; oe_n = 1'b1;
    ce1_n = 1'b0; ce2_n = 1'b0; we_n = 1'b0;
    settle();
    we_n = 1'b1;
    settle();
    idle_bus();
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [15:0] w);
    byte_n = 1'b1; addr = a; we_n = 1'b1; ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0;
    settle();
    w = dq_out;
    idle_bus();
  endtask

  task automatic t_reset();
    chk("R10 reset lanes", {29'b0, lo_oe, mid_oe, top_oe}, 32'd0);
    chk("R10 reset rdy", {31'b0, rdy}, 32'd1);
  endtask

  task automatic t_x16();
    logic [15:0] w;
    do_write(1'b1, 6'd3, 16'hA55A);
    do_write(1'b1, 6'd4, 16'h0F0F);
    do_write(1'b1, 6'd63, 16'hFFFF);
    byte_n = 1'b1; addr = 6'd3; ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0;
    settle();
    chk("R4 x16 lanes", {29'b0, lo_oe, mid_oe, top_oe}, 32'd7);
    chk("R4 R6 x16 word a3", {16'b0, dq_out}, 32'h0000A55A);
    idle_bus();
    read_word(6'd4, w);  chk("R6 x16 word a4", {16'b0, w}, 32'h00000F0F);
    read_word(6'd63, w); chk("R6 x16 word a63", {16'b0, w}, 32'h0000FFFF);
  endtask

  task automatic t_select();
    addr = 6'd3; oe_n = 1'b0; we_n = 1'b1; ce1_n = 1'b0; ce2_n = 1'b1;
    settle();
    chk("R1 only ce1 low", {29'b0, lo_oe, mid_oe, top_oe}, 32'd0);
    ce1_n = 1'b1; ce2_n = 1'b0;
    settle();
    chk("R1 only ce2 low", {29'b0, lo_oe, mid_oe, top_oe}, 32'd0);
    ce1_n = 1'b0;
    settle();
    chk("R1 both low", {29'b0, lo_oe, mid_oe, top_oe}, 32'd7);
    idle_bus();
  endtask

  task automatic t_x8_read();
    byte_n = 1'b0; addr = 6'd3; dq_in = 16'h0000;
    ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0;
    settle();
    chk("R5 x8 low byte", {16'b0, dq_out}, 32'h0000005A);
    chk("R5 x8 lanes", {29'b0, lo_oe, mid_oe, top_oe}, 32'd4);
    dq_in = 16'h8000;
    settle();
    chk("R5 x8 high byte", {16'b0, dq_out}, 32'h000000A5);
    chk("R5 x8 lanes hi", {29'b0, lo_oe, mid_oe, top_oe}, 32'd4);
    idle_bus();
  endtask

  task automatic t_x8_write();
    logic [15:0] w;
    do_write(1'b1, 6'd5, 16'h1234);
    do_write(1'b0, 6'd5, 16'h80AB);
    read_word(6'd5, w); chk("R6 x8 high byte write", {16'b0, w}, 32'h0000AB34);
    do_write(1'b0, 6'd5, 16'h00CD);
    read_word(6'd5, w); chk("R6 x8 low byte write", {16'b0, w}, 32'h0000ABCD);
  endtask

  task automatic t_oe_write();
    logic [15:0] w;
    byte_n = 1'b1; addr = 6'd4; dq_in = 16'hDEAD;
    ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    settle();
    chk("R7 read while we low", {16'b0, dq_out}, 32'h00000F0F);
    we_n = 1'b1;
    settle();
    oe_n = 1'b1;
    settle();
    chk("R3 output disable", {29'b0, lo_oe, mid_oe, top_oe}, 32'd0);
    idle_bus();
    read_word(6'd4, w); chk("R7 word unchanged", {16'b0, w}, 32'h00000F0F);
  endtask

  task automatic t_pdn();
    logic [15:0] w;
    pwd_n = 1'b0; busy_in = 1'b1; addr = 6'd3;
    ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0;
    settle();
    chk("R2 pdn lanes", {29'b0, lo_oe, mid_oe, top_oe}, 32'd0);
    chk("R2 pdn rdy", {31'b0, rdy}, 32'd1);
    idle_bus();
    busy_in = 1'b0;
    do_write(1'b1, 6'd3, 16'h1111);
    pwd_n = 1'b1;
    settle();
    read_word(6'd3, w); chk("R2 pdn write ignored", {16'b0, w}, 32'h0000A55A);
  endtask

  task automatic t_ident();
    byte_n = 1'b1; id_volt = 1'b1; ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0;
    addr = 6'd0; settle();
    chk("R8 maker code", {16'b0, dq_out}, 32'h000000C2);
    addr = 6'd1; settle();
    chk("R8 device code", {16'b0, dq_out}, 32'h000000FA);
    chk("R8 x16 lanes", {29'b0, lo_oe, mid_oe, top_oe}, 32'd7);
    addr = 6'b01_0010; settle();
    chk("R8 sector1 unprotected", {16'b0, dq_out}, 32'h00000000);
    addr = 6'b10_0010; settle();
    chk("R8 sector2 protected", {16'b0, dq_out}, 32'h00000001);
    addr = 6'd3; settle();
    chk("R8 reserved code", {16'b0, dq_out}, 32'h00000000);
    byte_n = 1'b0; addr = 6'd1; settle();
    chk("R8 x8 device code", {16'b0, dq_out}, 32'h000000FA);
    chk("R8 x8 lanes", {29'b0, lo_oe, mid_oe, top_oe}, 32'd4);
    idle_bus();
  endtask

  task automatic t_ready();
    busy_in = 1'b1; settle();
    chk("R9 busy", {31'b0, rdy}, 32'd0);
    ce1_n = 1'b0; ce2_n = 1'b0; oe_n = 1'b0; settle();
    chk("R9 busy while reading", {31'b0, rdy}, 32'd0);
    suspend_in = 1'b1; settle();
    chk("R9 suspended", {31'b0, rdy}, 32'd1);
    suspend_in = 1'b0; idle_bus();
    chk("R9 busy deselected", {31'b0, rdy}, 32'd0);
    busy_in = 1'b0; settle();
    chk("R9 idle", {31'b0, rdy}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_x16();
    t_select();
    t_x8_read();
    t_x8_write();
    t_oe_write();
    t_pdn();
    t_ident();
    t_ready();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule